// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The block collects up to eight interrupt requests, ranks them with a fixed, fully nested priority (input 0 wins), and raises a single interrupt line toward a processor. Software sets it up through a small byte-wide register port. There is one address bit. The control address takes a start-of-setup word, a status-selection command and an end-of-interrupt command, and tells them apart by bit pattern. The auxiliary address takes the rest of the setup words in sequence, and after setup it holds the mask register.

An acknowledge pulse moves the winning request into the in-service register. In the same cycle the block returns a vector byte built from the programmed base and the input index. Each input can be edge-triggered or level-triggered. A global mode bit sets the default, and a separate trigger-select register, reached through its own chip select, can force individual inputs to level sensing.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to the control address (`a0`=0) with `din[4]`=1 is the start word. It clears the in-service and mask registers, resets status reads to the request register, drops latched edge requests and restarts the setup sequence. In that word, `din[0]`=1 asks for a fourth setup word and `din[3]`=1 selects global level triggering.
- R2: After the start word, auxiliary writes (`a0`=1) are taken in order: the vector base, then a cascade word that is consumed and ignored, then a fourth word only if one was requested. Every later auxiliary write loads the mask register. An auxiliary read returns the mask.
- R3: A mask bit of 1 keeps the matching input from raising `irq` or being acknowledged.
- R4: `irq` is high only when some unmasked pending request has a lower index than every set in-service bit. Index 0 has the highest priority.
- R5: While `ack` is high, `vec` equals `{base[7:3], idx}`, where idx is the highest-priority eligible input. At the clock edge that input's in-service bit is set. With nothing eligible, idx is 7 and the in-service register is unchanged.
- R6: A control write of exactly 0x20 clears the lowest-index set bit of the in-service register.
- R7: A control write with `din[4]`=0 and `din[3]`=1 selects what control reads return. Low bits 11 select the in-service register and 10 select the request register. After a start word, control reads return the request register.
- R8: An edge-triggered input latches a request on a 0-to-1 transition, which survives the input falling again. Acknowledge clears it, and an input held high does not request again.
- R9: A level-triggered input's request bit equals the input level at all times.
- R10: With `tcs`=1, a write loads the trigger-select register and a read returns it. Bit i at 1 makes input i level-triggered whatever the global mode.
- R11: After reset, the mask register reads 0xFF and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select for the control and auxiliary addresses |
| tcs | input | 1 | Chip select for the trigger-select register |
| a0 | input | 1 | Address: 0 control, 1 auxiliary |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, one cycle per byte |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| req | input | 8 | Interrupt request inputs |
| irq | output | 1 | Interrupt to processor |
| ack | input | 1 | Acknowledge pulse |
| vec | output | 8 | Vector byte, valid while ack is high |

## Verification
The hardest state to reach is a nested one. A lower-priority input must already be in service while a higher one arrives and is taken, and a third input must wait behind both. End-of-interrupt commands then have to release the in-service bits in priority order, and the waiting input must be granted only once the last blocking bit clears. The bench builds this state by raising inputs one at a time and acknowledging between them. It reads the in-service register back through the status-select command after each step. Both trigger modes are reached by re-running the setup sequence with a different start word.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [7:0] MASK_AT_RESET = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       tcs,
  input  logic       a0,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] req,
  output logic       irq,
  input  logic       ack,
  output logic [7:0] vec
);

  typedef enum logic [1:0] {S_RUN, S_BASE, S_CASC, S_EXTRA} seq_t;

  seq_t       seq;
  logic       need_extra, glob_lvl, sel_isr;
  logic [7:0] vbase, imr, isr, trs, edge_q, req_d;

  logic       wr_ctl, wr_aux, start, stsel, eoi, take;
  logic [7:0] lvl_en, irr, low_isr, allowed, cand, grant, rise;
  logic [2:0] gidx;

  assign wr_ctl = cs & wr & ~a0;
  assign wr_aux = cs & wr & a0;
  assign start  = wr_ctl & din[4];
  assign stsel  = wr_ctl & ~din[4] & din[3];
  assign eoi    = wr_ctl & (din == 8'h20);

  assign lvl_en  = {8{glob_lvl}} | trs;
  assign rise    = req & ~req_d;
  assign irr     = (lvl_en & req) | (~lvl_en & edge_q);
  assign low_isr = isr & (~isr + 8'd1);
  assign allowed = (isr == 8'd0) ? 8'hFF : (low_isr - 8'd1);
  assign cand    = irr & ~imr & allowed;
  assign grant   = cand & (~cand + 8'd1);
  assign irq     = |cand;
  assign take    = ack & irq;

  always_comb begin
    gidx = 3'd7;
    for (int i = 7; i >= 0; i--)
      if (cand[i]) gidx = i[2:0];
  end

  assign vec = {vbase[7:3], gidx};

  always_comb begin
    dout = 8'd0;
    if (rd && cs)       dout = a0 ? imr : (sel_isr ? isr : irr);
    else if (rd && tcs) dout = trs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= 8'd0;
      edge_q <= 8'd0;
    end else begin
      req_d  <= req;
      edge_q <= start ? 8'd0 : ((edge_q | rise) & ~(take ? grant : 8'd0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= 8'd0;
    end else if (start) begin
      isr <= 8'd0;
    end else begin
      isr <= ((eoi ? (isr & ~low_isr) : isr)) | (take ? grant : 8'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq        <= S_RUN;
      need_extra <= 1'b0;
      glob_lvl   <= 1'b0;
      sel_isr    <= 1'b0;
      vbase      <= 8'd0;
      imr        <= MASK_AT_RESET;
      trs        <= 8'd0;
    end else begin
      if (tcs && wr && !cs) trs <= din;
      if (start) begin
        seq        <= S_BASE;
        need_extra <= din[0];
        glob_lvl   <= din[3];
        sel_isr    <= 1'b0;
        imr        <= 8'd0;
      end else if (stsel && din[1]) begin
        sel_isr <= din[0];
      end else if (wr_aux) begin
        unique case (seq)
          S_BASE:  begin vbase <= din; seq <= S_CASC; end
          S_CASC:  seq <= need_extra ? S_EXTRA : S_RUN;
          S_EXTRA: seq <= S_RUN;
          default: imr <= din;
        endcase
      end
    end
  end

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (isr == 8'd0) && (imr == 8'd0));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux && seq == S_RUN && !start) |=> imr == $past(din));

  // R3
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 8'hFF) |-> !irq);

  // R5
  ack_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_ctl) |=> $countones(isr) == $past($countones(isr)) + 1);

  // R5
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !wr_ctl) |=> $stable(isr));

  // R6
  eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr != 8'd0) |=> $countones(isr) == $past($countones(isr)) - 1);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs = 0, tcs = 0, a0 = 0, rd = 0, wr = 0, ack = 0;
  logic [7:0] din = 0, req = 0;
  logic [7:0] dout, vec;
  logic       irq;
  int         checks = 0, errors = 0, cycles = 0;
  bit         done = 0;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .tcs(tcs), .a0(a0), .rd(rd),
    .wr(wr), .din(din), .dout(dout), .req(req), .irq(irq), .ack(ack), .vec(vec));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic sel_t, input logic ad, input logic [7:0] d);
    @(negedge clk);
    cs = ~sel_t; tcs = sel_t; a0 = ad; din = d; wr = 1;
    @(negedge clk);
    cs = 0; tcs = 0; wr = 0;
  endtask

  task automatic rreg(input logic sel_t, input logic ad, output logic [7:0] d);
    @(negedge clk);
    cs = ~sel_t; tcs = sel_t; a0 = ad; rd = 1;
    #1 d = dout;
    rd = 0; cs = 0; tcs = 0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    ack = 1;
    #1 v = vec;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic set_req(input logic [7:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
  endtask

  task automatic rd_isr(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    wreg(0, 0, 8'h0B);
    rreg(0, 0, d);
    chk(tag, d, exp);
  endtask

  task automatic setup(input logic [7:0] w1, input logic [7:0] base);
    wreg(0, 0, w1);
    wreg(0, 1, base);
    wreg(0, 1, 8'h04);
    if (w1[0]) wreg(0, 1, 8'h01);
    wreg(0, 1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rreg(0, 1, d);
    chk("R11 mask after reset", d, 8'hFF);
    chk("R11 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    setup(8'h11, 8'h40);
    rreg(0, 1, d);
    chk("R2 mask after four-word setup", d, 8'h00);
    rreg(0, 0, d);
    chk("R7 default status is request reg", d, 8'h00);
  endtask

  task automatic t_vector();
    logic [7:0] v;
    set_req(8'h20);
    chk("R4 irq for pending input 5", {7'd0, irq}, 8'h01);
    do_ack(v);
    chk("R5 vector for input 5", v, 8'h45);
    rd_isr("R5 in-service after ack", 8'h20);
    chk("R8 edge request cleared by ack", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_nest();
    logic [7:0] v;
    set_req(8'h60);
    chk("R4 lower input blocked by in-service", {7'd0, irq}, 8'h00);
    set_req(8'h64);
    chk("R4 higher input breaks through", {7'd0, irq}, 8'h01);
    do_ack(v);
    chk("R5 vector for input 2", v, 8'h42);
    rd_isr("R5 nested in-service", 8'h24);
    wreg(0, 0, 8'h20);
    rd_isr("R6 first EOI clears input 2", 8'h20);
    chk("R4 input 6 still held off", {7'd0, irq}, 8'h00);
    wreg(0, 0, 8'h20);
    rd_isr("R6 second EOI clears input 5", 8'h00);
    chk("R4 input 6 released", {7'd0, irq}, 8'h01);
    do_ack(v);
    chk("R5 vector for input 6", v, 8'h46);
    wreg(0, 0, 8'h20);
    rd_isr("R6 EOI empties in-service", 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v, d;
    wreg(0, 1, 8'h08);
    set_req(8'h6C);
    chk("R3 masked input 3 silent", {7'd0, irq}, 8'h00);
    wreg(0, 0, 8'h0A);
    rreg(0, 0, d);
    chk("R7 request reg readback", d, 8'h08);
    wreg(0, 1, 8'h00);
    chk("R3 unmasked input 3 raises irq", {7'd0, irq}, 8'h01);
    do_ack(v);
    chk("R5 vector for input 3", v, 8'h43);
    wreg(0, 0, 8'h20);
    chk("R8 held-high input no retrigger", {7'd0, irq}, 8'h00);
    do_ack(v);
    chk("R5 spurious vector", v, 8'h47);
    rd_isr("R5 spurious ack leaves in-service", 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] v, d;
    set_req(8'h00);
    set_req(8'h02);
    do_ack(v);
    chk("R5 vector for input 1", v, 8'h41);
    rd_isr("R5 input 1 in service", 8'h02);
    set_req(8'h10);
    wreg(0, 0, 8'h18);
    wreg(0, 1, 8'h80);
    wreg(0, 1, 8'h00);
    wreg(0, 1, 8'h00);
    rreg(0, 1, d);
    chk("R2 no fourth word: third aux is mask", d, 8'h00);
    rreg(0, 0, d);
    chk("R1 status back to request reg", d, 8'h10);
    rd_isr("R1 start word cleared in-service", 8'h00);
    chk("R9 level input raises irq", {7'd0, irq}, 8'h01);
    @(negedge clk); req = 8'h00; #1;
    chk("R9 level input drop clears irq", {7'd0, irq}, 8'h00);
    set_req(8'h10);
    do_ack(v);
    chk("R5 vector with new base", v, 8'h84);
    set_req(8'h00);
    wreg(0, 0, 8'h20);
  endtask

  task automatic t_trig();
    logic [7:0] v, d;
    setup(8'h11, 8'h40);
    wreg(1, 0, 8'h01);
    rreg(1, 0, d);
    chk("R10 trigger-select readback", d, 8'h01);
    set_req(8'h01);
    chk("R10 input 0 level raises irq", {7'd0, irq}, 8'h01);
    @(negedge clk); req = 8'h00; #1;
    chk("R10 input 0 level drop clears irq", {7'd0, irq}, 8'h00);
    set_req(8'h80);
    set_req(8'h00);
    chk("R8 edge input 7 pulse stays latched", {7'd0, irq}, 8'h01);
    do_ack(v);
    chk("R5 vector for input 7", v, 8'h47);
    rd_isr("R5 input 7 in service", 8'h80);
    wreg(0, 0, 8'h20);
    rd_isr("R6 EOI clears input 7", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_init();
    t_vector();
    t_nest();
    t_mask();
    t_level();
    t_trig();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule